// File: doc/BRIEF.md
# Key-Tap Speed Meter

This block estimates how fast an operator is sending Morse code. It counts taps, meaning key-down events, on an active-low key line. The count is taken over a fixed observation window. At the end of each window the result goes onto a two-digit decimal display. An ordinary English word averages about twelve and a half taps. A window of 60 / 12.5 = 4.8 seconds therefore yields a tap count that reads directly as words per minute.

The key line idles high and is pulled low for key-down. It may come from a hand key, from an electronic keyer, or from a squared-up audio detector. All three sources enter through the same input. The line is brought into the clock domain by a synchronizer and then debounced. A tap is recognised only on a falling edge of the debounced level.

An external periodic tick sets the window length. The window is a parameterised number of ticks: 480 ticks at 10 ms give 4.8 s. At the end of a window the running count is copied into a display register. One cycle later the running count is cleared. The displayed value therefore stays steady for the whole of the next window.

Top module: `tap_speed_meter`

## Requirements
- R1: While reset is asserted, and after it is released until the first window ends, both displayed digits are 0.
- R2: The key line is active low. A tap is counted once per key-down, after the two-stage synchronizer, once the synchronized line has been low for DEBOUNCE_CYCLES consecutive clock cycles. A low period of exactly DEBOUNCE_CYCLES cycles at the pin counts.
- R3: A low pulse shorter than DEBOUNCE_CYCLES adds nothing to the count. A high glitch shorter than DEBOUNCE_CYCLES inside a key-down does not split that key-down into two taps.
- R4: A window spans WINDOW_TICKS pulses on `tick_i`. Two clock edges after the edge that samples the window's last tick, the digits show the number of taps counted in that window.
- R5: The display capture happens exactly one cycle before the running count is cleared. The displayed value is therefore the full window count and never a cleared zero.
- R6: A window with more than 99 taps displays 99.
- R7: Between two window ends the displayed digits do not change, whatever the key line does.
- R8: A tap that is recognised in the capture cycle is not lost. It is carried into the count of the next window.
- R9: Digits are BCD, 0 to 9. Each segment output is active high, with bit 0 = segment a through bit 6 = segment g. The patterns are 0=0x3F, 1=0x06, 2=0x5B, 3=0x4F, 4=0x66, 5=0x6D, 6=0x7D, 7=0x07, 8=0x7F and 9=0x6F.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| key_n_i | input | 1 | Key or detector line, low while key is down |
| tick_i | input | 1 | One-cycle time-base pulse; WINDOW_TICKS of them make a window |
| tens_o | output | 4 | Displayed tens digit, BCD |
| ones_o | output | 4 | Displayed ones digit, BCD |
| seg_tens_o | output | 7 | Segment pattern for tens digit |
| seg_ones_o | output | 7 | Segment pattern for ones digit |

## Verification
The bench builds the block with DEBOUNCE_CYCLES = 4 and WINDOW_TICKS = 8, and issues a tick every 120 cycles. A window is then 960 cycles long. That is long enough to fit more than a hundred debounced taps, which reaches saturation, yet short enough to run many windows.

With a 4-cycle debounce, pulses at exactly the threshold and one cycle below it can be placed precisely. A key fall can also be timed so that its tap lands in the capture cycle. The per-cycle reference model tracks the synchronizer, the debounce, the window and the carried tap, and checks every displayed digit and segment on each clock.

// File: rtl/tsm_pkg.sv
package tsm_pkg;

  localparam int unsigned SEG_W   = 7;
  localparam int unsigned DIGIT_W = 4;

  typedef logic [DIGIT_W-1:0] bcd_t;

  // Active-high segments, bit 0 = a ... bit 6 = g
  function automatic logic [SEG_W-1:0] bcd_to_seg(input bcd_t d);
    logic [SEG_W-1:0] s;
    case (d)
      4'd0:    s = 7'b0111111;
      4'd1:    s = 7'b0000110;
      4'd2:    s = 7'b1011011;
      4'd3:    s = 7'b1001111;
      4'd4:    s = 7'b1100110;
      4'd5:    s = 7'b1101101;
      4'd6:    s = 7'b1111101;
      4'd7:    s = 7'b0000111;
      4'd8:    s = 7'b1111111;
      4'd9:    s = 7'b1101111;
      default: s = 7'b0000000;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/tsm_debounce.sv
module tsm_debounce #(
  parameter int unsigned SYNC_STAGES     = 2,
  parameter int unsigned DEBOUNCE_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic key_n_i,
  output logic tap_o
);

  localparam int unsigned CW = $clog2(DEBOUNCE_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(DEBOUNCE_CYCLES - 1);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic [CW-1:0]          cnt_q, cnt_d;
  logic                   lvl_q, lvl_d;
  logic                   tap_q, tap_d;
  logic                   key_s;

  assign key_s = sync_q[SYNC_STAGES-1];

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], key_n_i};
    cnt_d  = cnt_q;
    lvl_d  = lvl_q;
    tap_d  = 1'b0;
    if (key_s != lvl_q) begin
      if (cnt_q == CNT_LAST) begin
        lvl_d = key_s;
        cnt_d = '0;
        tap_d = ~key_s;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      cnt_q  <= '0;
      lvl_q  <= 1'b1;
      tap_q  <= 1'b0;
    end else begin
      sync_q <= sync_d;
      cnt_q  <= cnt_d;
      lvl_q  <= lvl_d;
      tap_q  <= tap_d;
    end
  end

  assign tap_o = tap_q;

  // R2: a tap comes only with a low debounced level reached from a low synchronized line
  assert_tap_on_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tap_q |-> (!lvl_q && $past(!key_s)));

  // R3: the debounced level falls only after the full run of low samples
  assert_fall_after_run_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lvl_q) |-> ($past(cnt_q) == CNT_LAST));

  // R2: never two taps in adjacent cycles
  assert_tap_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tap_q |=> !tap_q);

endmodule

// File: rtl/tsm_window.sv
module tsm_window #(
  parameter int unsigned WINDOW_TICKS = 480
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic latch_o,
  output logic clear_o
);

  localparam int unsigned TW = $clog2(WINDOW_TICKS + 1);
  localparam logic [TW-1:0] TICK_LAST = TW'(WINDOW_TICKS - 1);

  logic [TW-1:0] tcnt_q, tcnt_d;
  logic          latch_q, latch_d;
  logic          clear_q, clear_d;

  always_comb begin
    tcnt_d  = tcnt_q;
    latch_d = 1'b0;
    clear_d = latch_q;
    if (tick_i) begin
      if (tcnt_q == TICK_LAST) begin
        tcnt_d  = '0;
        latch_d = 1'b1;
      end else begin
        tcnt_d = tcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tcnt_q  <= '0;
      latch_q <= 1'b0;
      clear_q <= 1'b0;
    end else begin
      tcnt_q  <= tcnt_d;
      latch_q <= latch_d;
      clear_q <= clear_d;
    end
  end

  assign latch_o = latch_q;
  assign clear_o = clear_q;

  // R5: every clear is preceded by a capture one cycle earlier
  assert_clear_follows_latch_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_q |-> $past(latch_q));

  // R5: every capture is followed by a clear
  assert_latch_then_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_q |=> clear_q);

endmodule

// File: rtl/tsm_bcd_count.sv
module tsm_bcd_count
  import tsm_pkg::*;
#(
  parameter int unsigned DIGITS = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    tap_i,
  input  logic                    latch_i,
  input  logic                    clear_i,
  output logic [DIGITS-1:0][DIGIT_W-1:0] value_o
);

  logic [DIGITS-1:0][DIGIT_W-1:0] val_q, val_d, val_inc;
  logic                           pend_q, pend_d;
  logic                           at_max;

  // Saturating decimal increment, ripple carry across digits
  always_comb begin
    logic carry;
    carry   = 1'b1;
    val_inc = val_q;
    at_max  = 1'b1;
    for (int i = 0; i < DIGITS; i++) begin
      if (val_q[i] != 4'd9) at_max = 1'b0;
      if (carry) begin
        if (val_q[i] == 4'd9) begin
          val_inc[i] = '0;
        end else begin
          val_inc[i] = val_q[i] + 1'b1;
          carry      = 1'b0;
        end
      end
    end
  end

  always_comb begin
    val_d  = val_q;
    pend_d = pend_q;
    if (clear_i) begin
      val_d    = '0;
      val_d[0] = {3'b000, pend_q} + {3'b000, tap_i};
      pend_d   = 1'b0;
    end else if (latch_i) begin
      pend_d = tap_i;
    end else if (tap_i && !at_max) begin
      val_d = val_inc;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      val_q  <= val_d;
      pend_q <= pend_d;
    end
  end

  assign value_o = val_q;

  // R6: a full counter holds on further taps
  assert_hold_at_max_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_max && tap_i && !latch_i && !clear_i) |=> $stable(val_q));

  // R9: every digit stays a decimal digit
  for (genvar g = 0; g < DIGITS; g++) begin : g_dig_chk
    assert_digit_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      val_q[g] <= 4'd9);
  end

  // R8: a tap taken during capture reaches the count at the clear
  assert_carry_tap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_i && tap_i && !clear_i) |=> (val_q[0] != 4'd0 || val_d[0] != 4'd0));

endmodule

// File: rtl/tap_speed_meter.sv
module tap_speed_meter
  import tsm_pkg::*;
#(
  parameter int unsigned SYNC_STAGES     = 2,
  parameter int unsigned DEBOUNCE_CYCLES = 500000,
  parameter int unsigned WINDOW_TICKS    = 480
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       key_n_i,
  input  logic       tick_i,
  output logic [3:0] tens_o,
  output logic [3:0] ones_o,
  output logic [6:0] seg_tens_o,
  output logic [6:0] seg_ones_o
);

  localparam int unsigned DIGITS = 2;

  logic [1:0] rst_sync_q;
  logic       rst_n;
  logic       tap, latch, clear;
  logic [DIGITS-1:0][DIGIT_W-1:0] live_val;
  logic [DIGITS-1:0][DIGIT_W-1:0] disp_q, disp_d;
  logic [DIGITS-1:0][SEG_W-1:0]   seg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  tsm_debounce #(
    .SYNC_STAGES    (SYNC_STAGES),
    .DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)
  ) u_debounce (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .key_n_i(key_n_i),
    .tap_o  (tap)
  );

  tsm_window #(
    .WINDOW_TICKS(WINDOW_TICKS)
  ) u_window (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .tick_i (tick_i),
    .latch_o(latch),
    .clear_o(clear)
  );

  tsm_bcd_count #(
    .DIGITS(DIGITS)
  ) u_count (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .tap_i  (tap),
    .latch_i(latch),
    .clear_i(clear),
    .value_o(live_val)
  );

  always_comb begin
    disp_d = disp_q;
    if (latch) disp_d = live_val;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) disp_q <= '0;
    else        disp_q <= disp_d;
  end

  for (genvar g = 0; g < DIGITS; g++) begin : g_seg
    assign seg[g] = bcd_to_seg(disp_q[g]);
  end

  assign ones_o     = disp_q[0];
  assign tens_o     = disp_q[1];
  assign seg_ones_o = seg[0];
  assign seg_tens_o = seg[1];

  // R7: the display only moves on a capture
  assert_disp_steady_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    !latch |=> $stable(disp_q));

  // R5: a capture takes the running count before any clear
  assert_capture_live_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (latch && !clear) |=> (disp_q == $past(live_val)));

endmodule

// File: tb/test_tap_speed_meter.sv
module test_tap_speed_meter;

  localparam int DEB = 4;
  localparam int W   = 8;
  localparam int TP  = 120;
  localparam int WIN = W * TP;
  localparam int OFF = 20;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       key_n_i = 1'b1;
  logic       tick_i = 1'b0;
  logic [3:0] tens_o, ones_o;
  logic [6:0] seg_tens_o, seg_ones_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  bit cmp_en = 0;

  always #5 clk_i = ~clk_i;

  tap_speed_meter #(
    .SYNC_STAGES    (2),
    .DEBOUNCE_CYCLES(DEB),
    .WINDOW_TICKS   (W)
  ) i_tap_speed_meter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .key_n_i   (key_n_i),
    .tick_i    (tick_i),
    .tens_o    (tens_o),
    .ones_o    (ones_o),
    .seg_tens_o(seg_tens_o),
    .seg_ones_o(seg_ones_o)
  );

  function automatic int seg_of(input int d);
    case (d)
      0: return 'h3F; 1: return 'h06; 2: return 'h5B; 3: return 'h4F;
      4: return 'h66; 5: return 'h6D; 6: return 'h7D; 7: return 'h07;
      8: return 'h7F; 9: return 'h6F;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: time-line of samples and run lengths
  int m_rs0 = 0, m_rs1 = 0;
  int m_hist[$] = '{1, 1};
  int m_level = 1, m_run = 0, m_tap = 0;
  int m_ticks = 0, m_cap = 0, m_clr = 0, m_carry = 0;
  int m_count = 0, m_shown = 0;

  always @(posedge clk_i) begin
    int seen, n_level, n_run, n_tap, n_ticks, n_cap, n_count, n_carry, n_shown;
    bit in_rst;
    in_rst = (!rst_ni) || (m_rs1 == 0);
    if (!rst_ni) begin m_rs0 = 0; m_rs1 = 0; end
    else begin m_rs1 = m_rs0; m_rs0 = 1; end
    if (in_rst) begin
      m_hist = '{1, 1}; m_level = 1; m_run = 0; m_tap = 0;
      m_ticks = 0; m_cap = 0; m_clr = 0; m_carry = 0; m_count = 0; m_shown = 0;
    end else begin
      seen = m_hist[0];
      n_level = m_level; n_run = 0; n_tap = 0;
      if (seen != m_level) begin
        if (m_run + 1 >= DEB) begin n_level = seen; n_tap = (seen == 0); end
        else n_run = m_run + 1;
      end
      n_ticks = m_ticks; n_cap = 0;
      if (tick_i) begin
        if (m_ticks + 1 == W) begin n_ticks = 0; n_cap = 1; end
        else n_ticks = m_ticks + 1;
      end
      n_count = m_count; n_carry = m_carry;
      if (m_clr) begin n_count = m_carry + m_tap; n_carry = 0; end
      else if (m_cap) n_carry = m_tap;
      else if (m_tap) n_count = (m_count >= 99) ? 99 : m_count + 1;
      n_shown = m_cap ? m_count : m_shown;
      m_hist.delete(0);
      m_hist.push_back(int'(key_n_i));
      m_clr = m_cap; m_cap = n_cap; m_ticks = n_ticks;
      m_level = n_level; m_run = n_run; m_tap = n_tap;
      m_count = n_count; m_carry = n_carry; m_shown = n_shown;
    end
  end

  // Per-cycle comparison against the reference (R4, R9)
  always @(negedge clk_i) begin
    if (cmp_en) begin
      chk(int'(tens_o) == m_shown / 10, "R4 model tens", tens_o, m_shown / 10);
      chk(int'(ones_o) == m_shown % 10, "R4 model ones", ones_o, m_shown % 10);
      chk(int'(seg_tens_o) == seg_of(m_shown / 10), "R9 model seg tens",
          seg_tens_o, seg_of(m_shown / 10));
      chk(int'(seg_ones_o) == seg_of(m_shown % 10), "R9 model seg ones",
          seg_ones_o, seg_of(m_shown % 10));
    end
  end

  int prev_show = 0;

  // One full window: ntaps presses of low/high lengths, optional extra fall,
  // optional short high glitch inside each press
  task automatic run_window(input int ntaps, input int lowlen, input int highlen,
                            input int extra_fall, input int glitch, input int exp,
                            input string tag);
    int per;
    per = lowlen + highlen;
    for (int cyc = 0; cyc < WIN; cyc++) begin
      bit low;
      @(negedge clk_i);
      tick_i = ((cyc % TP) == TP - 1);
      low = 1'b0;
      if (cyc >= OFF && (cyc - OFF) / per < ntaps && (cyc - OFF) % per < lowlen) begin
        low = 1'b1;
        if (glitch > 0 && (cyc - OFF) % per >= lowlen / 2 &&
            (cyc - OFF) % per < lowlen / 2 + glitch) low = 1'b0;
      end
      if (extra_fall >= 0 && cyc >= extra_fall) low = 1'b1;
      key_n_i = ~low;
      if (cyc == WIN / 2)
        chk(int'(tens_o) * 10 + int'(ones_o) == prev_show, "R7 steady mid-window",
            int'(tens_o) * 10 + int'(ones_o), prev_show);
    end
    @(negedge clk_i); tick_i = 1'b0; key_n_i = 1'b1;
    @(negedge clk_i);
    chk(int'(tens_o) * 10 + int'(ones_o) == exp, tag,
        int'(tens_o) * 10 + int'(ones_o), exp);
    prev_show = exp;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk(tens_o == 4'd0 && ones_o == 4'd0, "R1 digits in reset",
        int'(tens_o) * 10 + int'(ones_o), 0);
    chk(seg_tens_o == 7'h3F && seg_ones_o == 7'h3F, "R1 R9 segments in reset",
        int'(seg_ones_o), 'h3F);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    cmp_en = 1'b1;
    chk(tens_o == 4'd0 && ones_o == 4'd0, "R1 digits after release",
        int'(tens_o) * 10 + int'(ones_o), 0);

    run_window(7, DEB + 2, DEB + 2, -1, 0, 7, "R4 seven taps");
    run_window(23, DEB, DEB, -1, 0, 23, "R2 exact debounce length");
    run_window(12, DEB - 1, DEB + 3, -1, 0, 0, "R3 short pulses ignored");
    run_window(5, 3 * DEB, 2 * DEB, -1, DEB - 1, 5, "R3 glitch inside press");
    chk(seg_ones_o == 7'h6D && seg_tens_o == 7'h3F, "R9 segments for 05",
        int'(seg_ones_o), 'h6D);
    run_window(110, DEB, DEB, -1, 0, 99, "R6 saturate at 99");
    chk(seg_ones_o == 7'h6F && seg_tens_o == 7'h6F, "R9 segments for 99",
        int'(seg_tens_o), 'h6F);
    // R8: fall timed so the tap is recognised in the capture cycle
    run_window(4, DEB + 2, DEB + 2, WIN - 1 - DEB - 1, 0, 4, "R8 boundary window");
    run_window(2, DEB + 2, DEB + 2, -1, 0, 3, "R8 carried tap counted");
    run_window(0, DEB, DEB, -1, 0, 0, "R5 idle window shows zero");
    run_window(38, DEB + 1, DEB + 7, -1, 0, 38, "R5 full count captured");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule